// File: doc/BRIEF.md
# Reset Source Status Register

This block keeps the record of why the chip last came out of reset. Each hardware reset source has a status flag. When the reset controller finishes a reset, it raises a one-cycle capture strobe. On that strobe the block stores the set of sources that were requesting, and it samples the wake-up configuration pin and the two boot configuration pins. The record then holds until the next capture, so software can read the cause at any time after boot.

A software-triggered external reset works differently. It adds its own flag to the record and disturbs nothing that was already there. A separate sticky flag records glitches seen on the external reset input. It is set by a one-cycle pulse from an outside detector, and software clears it by writing 1 to it.

The status word sits at offset 0x0C of a small register bus. A companion control word sits at 0x10. That control word is a plain read/write register, except for one self-clearing bit that fires the software external reset.

Top module: `rst_status_regblk`

## Requirements
- R1: A power-on reset (`rst` high at a clock edge) clears every field of both words, the glitch flag included. Afterwards reads of 0x0C and 0x10 return 0.
- R2: On a cycle with `rst_capture_i` high, status bits [NUM_SRC-1:0] take the value of `rst_src_i`. Every source requesting in that cycle is recorded together.
- R3: Source bits hold while no capture occurs. A later capture replaces the whole set, and it clears the software-reset flag (bit 8) unless `sw_ext_req_i` is high in that same cycle.
- R4: A software external reset sets bit 8. It may come from `sw_ext_req_i` or from the control-word strobe. The source bits and the configuration fields stay unchanged.
- R5: The wake-up pin level is stored in bit 16 and the boot pins in bits [18:17], only on a capture. Pin changes at other times, including during a software external reset, do not alter these fields.
- R6: The glitch flag in bit 15 is set by `glitch_pulse_i`. A write to 0x0C with byte strobe 1 active and data bit 15 at 1 clears it. Writing 0 there leaves it set, and a capture does not clear it.
- R7: If a glitch pulse and a write-1 clear happen in the same cycle, the flag ends up set.
- R8: Bus writes to 0x0C change no status bit other than the glitch clear. Unused bit positions read as 0.
- R9: The control word at 0x10 stores written bytes according to `bus_be_i`. Bit 0 fires the software external reset. Writing 1 there drives `sw_ext_rst_o` high for exactly one cycle, and the bit then reads back 0.
- R10: Reads return their data one cycle after `bus_rd_i`. Addresses other than 0x0C and 0x10 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_capture_i | input | 1 | One-cycle strobe: record the completed reset |
| rst_src_i | input | NUM_SRC | Per-source reset requests, sampled on capture |
| sw_ext_req_i | input | 1 | One-cycle software external reset strobe |
| cfg_wake_i | input | 1 | Wake-up configuration pin level |
| cfg_boot_i | input | 2 | Boot configuration pin levels |
| glitch_pulse_i | input | 1 | One-cycle glitch detection pulse |
| bus_rd_i | input | 1 | Read request |
| bus_wr_i | input | 1 | Write request |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_be_i | input | 4 | Byte strobes for writes |
| bus_rdata_o | output | 32 | Registered read data |
| sw_ext_rst_o | output | 1 | One-cycle software external reset strobe from the control word |

## Verification
The hardest case to reach is the exact cycle in which the glitch detector's pulse meets a software write-1 clear. The bench raises the pulse inside the write task, in the same low clock phase in which it drives the write, so that both land on one edge.

The other delicate case is a software reset that reaches the status logic while the configuration pins have been moved away from their captured levels. The bench changes the pins between captures and checks that only a true capture picks them up.

// File: rtl/rsr_pkg.sv
package rsr_pkg;
  localparam int DATA_W   = 32;
  localparam int BE_W     = DATA_W / 8;
  localparam int SERF_POS = 8;
  localparam int GLT_POS  = 15;
  localparam int WAKE_POS = 16;
  localparam int BOOT_POS = 17;
  localparam int BOOT_W   = 2;
  localparam int SWX_POS  = 0;
  localparam int STAT_OFS = 12;
  localparam int CTRL_OFS = 16;
endpackage

// File: rtl/rsr_src_record.sv
module rsr_src_record #(
  parameter int NUM_SRC = 4,
  parameter int BOOT_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               capture_i,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic               swx_i,
  input  logic               wake_i,
  input  logic [BOOT_W-1:0]  boot_i,
  output logic [NUM_SRC-1:0] src_o,
  output logic               serf_o,
  output logic               wake_o,
  output logic [BOOT_W-1:0]  boot_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      src_o  <= '0;
      serf_o <= 1'b0;
      wake_o <= 1'b0;
      boot_o <= '0;
    end else if (capture_i) begin
      src_o  <= src_req_i;
      serf_o <= swx_i;
      wake_o <= wake_i;
      boot_o <= boot_i;
    end else if (swx_i) begin
      serf_o <= 1'b1;
    end
  end

  // R2: a capture loads the requesting set
  p_capture_load_r2: assert property (@(posedge clk) disable iff (rst)
    capture_i |=> src_o == $past(src_req_i));
  // R3: sources hold between captures
  p_src_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !capture_i |=> $stable(src_o));
  // R4: software reset only adds its flag
  p_serf_add_r4: assert property (@(posedge clk) disable iff (rst)
    (swx_i && !capture_i) |=> serf_o);
  // R5: configuration fields change only on capture
  p_cfg_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !capture_i |=> ($stable(wake_o) && $stable(boot_o)));
endmodule

// File: rtl/rsr_glitch_flag.sv
module rsr_glitch_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R7: set wins over a simultaneous clear
  p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  // R6: write-1 clear without a set empties the flag
  p_w1c_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_i && !set_i) |=> !flag_o);
  // R6: sticky otherwise
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !set_i) |=> $stable(flag_o));
endmodule

// File: rtl/rsr_ctrl_reg.sv
module rsr_ctrl_reg #(
  parameter int DATA_W  = 32,
  parameter int SWX_POS = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   word_o,
  output logic                swx_o
);
  localparam int BE_W = DATA_W / 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o <= '0;
    end else begin
      word_o[SWX_POS] <= 1'b0;
      for (int b = 0; b < BE_W; b++) begin
        if (wr_i && be_i[b]) word_o[b*8 +: 8] <= wdata_i[b*8 +: 8];
      end
    end
  end

  assign swx_o = word_o[SWX_POS];

  // R9: the strobe lasts one cycle unless rewritten
  p_strobe_once_r9: assert property (@(posedge clk) disable iff (rst)
    (swx_o && !(wr_i && be_i[SWX_POS/8] && wdata_i[SWX_POS])) |=> !swx_o);
  // R9: unwritten control bytes hold
  p_ctrl_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !wr_i |=> ($stable(word_o[DATA_W-1:8]) && !word_o[SWX_POS]));
endmodule

// File: rtl/rst_status_regblk.sv
module rst_status_regblk
  import rsr_pkg::*;
#(
  parameter int NUM_SRC = 4,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rst_capture_i,
  input  logic [NUM_SRC-1:0] rst_src_i,
  input  logic               sw_ext_req_i,
  input  logic               cfg_wake_i,
  input  logic [1:0]         cfg_boot_i,
  input  logic               glitch_pulse_i,
  input  logic               bus_rd_i,
  input  logic               bus_wr_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [31:0]        bus_wdata_i,
  input  logic [3:0]         bus_be_i,
  output logic [31:0]        bus_rdata_o,
  output logic               sw_ext_rst_o
);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_OFS);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_OFS);

  logic               sel_stat, sel_ctrl;
  logic               swx_any, glt_clr, glt_flag;
  logic [NUM_SRC-1:0] src_q;
  logic               serf_q, wake_q;
  logic [BOOT_W-1:0]  boot_q;
  logic [DATA_W-1:0]  ctrl_word, stat_word;

  assign sel_stat = (bus_addr_i == STAT_A);
  assign sel_ctrl = (bus_addr_i == CTRL_A);
  assign swx_any  = sw_ext_req_i | sw_ext_rst_o;
  assign glt_clr  = bus_wr_i && sel_stat && bus_be_i[GLT_POS/8] && bus_wdata_i[GLT_POS];

  rsr_src_record #(.NUM_SRC(NUM_SRC), .BOOT_W(BOOT_W)) u_record (
    .clk(clk), .rst(rst), .capture_i(rst_capture_i), .src_req_i(rst_src_i),
    .swx_i(swx_any), .wake_i(cfg_wake_i), .boot_i(cfg_boot_i),
    .src_o(src_q), .serf_o(serf_q), .wake_o(wake_q), .boot_o(boot_q)
  );

  rsr_glitch_flag u_glitch (
    .clk(clk), .rst(rst), .set_i(glitch_pulse_i), .clr_i(glt_clr), .flag_o(glt_flag)
  );

  rsr_ctrl_reg #(.DATA_W(DATA_W), .SWX_POS(SWX_POS)) u_ctrl (
    .clk(clk), .rst(rst), .wr_i(bus_wr_i && sel_ctrl), .be_i(bus_be_i),
    .wdata_i(bus_wdata_i), .word_o(ctrl_word), .swx_o(sw_ext_rst_o)
  );

  always_comb begin
    stat_word = '0;
    stat_word[NUM_SRC-1:0]               = src_q;
    stat_word[SERF_POS]                  = serf_q;
    stat_word[GLT_POS]                   = glt_flag;
    stat_word[WAKE_POS]                  = wake_q;
    stat_word[BOOT_POS +: BOOT_W]        = boot_q;
  end

  always_ff @(posedge clk) begin
    if (rst)           bus_rdata_o <= '0;
    else if (bus_rd_i) bus_rdata_o <= sel_stat ? stat_word :
                                      sel_ctrl ? ctrl_word : '0;
  end

  // R10: unmapped reads return zero
  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && !sel_stat && !sel_ctrl) |=> bus_rdata_o == '0);
  // R8: unused status positions read zero
  p_unused_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_i && sel_stat) |=> (bus_rdata_o[7:NUM_SRC] == '0 && bus_rdata_o[14:9] == '0
                                && bus_rdata_o[31:BOOT_POS+BOOT_W] == '0));
  // R10: read data holds without a read
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd_i |=> $stable(bus_rdata_o));
endmodule

// File: tb/rst_status_regblk_tb.sv
module rst_status_regblk_tb_top;
  localparam int CLK_P = 10;
  localparam int NSRC  = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cap = 0, swreq = 0, wake = 0, gp = 0, rd = 0, wr = 0;
  logic [NSRC-1:0] src = '0;
  logic [1:0] boot = '0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [3:0] be = '0;
  logic swx_o;

  int checks = 0, fails = 0;
  logic [NSRC-1:0] m_src = '0;
  logic m_serf = 0, m_glt = 0, m_wake = 0;
  logic [1:0] m_boot = '0;
  logic [31:0] m_ctrl = '0;

  always #(CLK_P/2) clk = ~clk;

  rst_status_regblk #(.NUM_SRC(NSRC), .ADDR_W(8)) dut_i (
    .clk(clk), .rst(rst), .rst_capture_i(cap), .rst_src_i(src), .sw_ext_req_i(swreq),
    .cfg_wake_i(wake), .cfg_boot_i(boot), .glitch_pulse_i(gp), .bus_rd_i(rd),
    .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_be_i(be),
    .bus_rdata_o(rdata), .sw_ext_rst_o(swx_o));

  function automatic logic [31:0] exp_stat();
    logic [31:0] w = '0;
    w[NSRC-1:0] = m_src; w[8] = m_serf; w[15] = m_glt; w[16] = m_wake; w[18:17] = m_boot;
    return w;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd_word(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd = 1; addr = a;
    @(posedge clk); @(negedge clk); d = rdata; rd = 0;
  endtask

  task automatic wr_word(input logic [7:0] a, input logic [31:0] d, input logic [3:0] b,
                         input logic pulse);
    @(negedge clk); wr = 1; addr = a; wdata = d; be = b; gp = pulse;
    @(posedge clk); @(negedge clk); wr = 0; be = '0; gp = 0;
  endtask

  task automatic capture(input logic [NSRC-1:0] s, input logic w, input logic [1:0] bt);
    @(negedge clk); cap = 1; src = s; wake = w; boot = bt;
    @(posedge clk); @(negedge clk); cap = 0; src = '0;
    m_src = s; m_serf = 0; m_wake = w; m_boot = bt;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_word(8'h0C, d); chk("R1 status after power-on", d, 32'h0);
    rd_word(8'h10, d); chk("R1 control after power-on", d, 32'h0);
  endtask

  task automatic t_capture_hold();
    logic [31:0] d;
    capture(4'b0101, 1'b1, 2'b10);
    rd_word(8'h0C, d); chk("R2 R5 capture 0101 wake1 boot10", d, 32'h0005_0005);
    @(negedge clk); wake = 0; boot = 2'b01;
    repeat (5) @(posedge clk);
    rd_word(8'h0C, d); chk("R3 R5 hold with pins moved", d, exp_stat());
    capture(4'b0010, 1'b0, 2'b01);
    rd_word(8'h0C, d); chk("R3 later capture replaces", d, 32'h0002_0002);
    capture(4'b1111, 1'b1, 2'b11);
    rd_word(8'h0C, d); chk("R2 all sources together", d, exp_stat());
  endtask

  task automatic t_sw_input();
    logic [31:0] d;
    @(negedge clk); wake = 0; boot = 2'b00; swreq = 1;
    @(posedge clk); @(negedge clk); swreq = 0; m_serf = 1;
    rd_word(8'h0C, d); chk("R4 R5 sw reset adds flag only", d, exp_stat());
    capture(4'b1000, 1'b0, 2'b01);
    rd_word(8'h0C, d); chk("R3 capture clears sw flag", d, exp_stat());
  endtask

  task automatic t_ctrl();
    logic [31:0] d;
    wr_word(8'h10, 32'hA5A5_5A01, 4'hF, 1'b0);
    chk("R9 strobe high after write", {31'b0, swx_o}, 32'h1);
    @(negedge clk);
    chk("R9 strobe one cycle", {31'b0, swx_o}, 32'h0);
    m_serf = 1; m_ctrl = 32'hA5A5_5A00;
    rd_word(8'h10, d); chk("R9 control bit0 self-clears", d, m_ctrl);
    rd_word(8'h0C, d); chk("R4 control strobe sets flag", d, exp_stat());
    wr_word(8'h10, 32'hFFFF_FFFF, 4'b0100, 1'b0);
    m_ctrl = 32'hA5FF_5A00;
    rd_word(8'h10, d); chk("R9 byte strobes", d, m_ctrl);
    chk("R9 no strobe without lane0", {31'b0, swx_o}, 32'h0);
  endtask

  task automatic t_glitch();
    logic [31:0] d;
    @(negedge clk); gp = 1; @(posedge clk); @(negedge clk); gp = 0; m_glt = 1;
    rd_word(8'h0C, d); chk("R6 glitch pulse sets flag", d, exp_stat());
    wr_word(8'h0C, 32'h0000_0000, 4'hF, 1'b0);
    rd_word(8'h0C, d); chk("R6 write 0 keeps flag", d, exp_stat());
    wr_word(8'h0C, 32'hFFFF_FFFF, 4'b1101, 1'b0);
    rd_word(8'h0C, d); chk("R8 R6 writes ignored without lane1", d, exp_stat());
    wr_word(8'h0C, 32'h0000_8000, 4'b0010, 1'b0); m_glt = 0;
    rd_word(8'h0C, d); chk("R6 write 1 clears flag", d, exp_stat());
    wr_word(8'h0C, 32'h0000_8000, 4'b0010, 1'b1); m_glt = 1;
    rd_word(8'h0C, d); chk("R7 set wins over clear", d, exp_stat());
    capture(4'b0001, 1'b1, 2'b00);
    rd_word(8'h0C, d); chk("R6 capture keeps glitch flag", d, exp_stat());
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd_word(8'h00, d); chk("R10 read 0x00 zero", d, 32'h0);
    wr_word(8'h14, 32'hFFFF_FFFF, 4'hF, 1'b0);
    rd_word(8'h14, d); chk("R10 read 0x14 zero", d, 32'h0);
    rd_word(8'h10, d); chk("R10 unmapped write no effect", d, m_ctrl);
    rd_word(8'h0C, d); chk("R10 status unaffected", d, exp_stat());
  endtask

  task automatic t_por();
    logic [31:0] d;
    @(negedge clk); rst = 1; @(posedge clk); @(negedge clk); rst = 0;
    m_src = '0; m_serf = 0; m_glt = 0; m_wake = 0; m_boot = '0; m_ctrl = '0;
    rd_word(8'h0C, d); chk("R1 power-on clears glitch and record", d, 32'h0);
    rd_word(8'h10, d); chk("R1 power-on clears control", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    t_reset();
    t_capture_hold();
    t_sw_input();
    t_ctrl();
    t_glitch();
    t_unmapped();
    t_por();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule